// File: doc/BRIEF.md
# Triple-Lane Majority Output Voter

This block sits between three redundant compute lanes and the downstream consumers of their results. A frame strobe opens a vote window of fixed length. During that window each lane hands over one data word with a valid pulse. When the window closes, the block compares the captured words as whole words and forwards the value that at least two lanes agree on. A lane that is outvoted, or that delivers nothing inside the window, is marked in a per-lane sticky flag.

The flags keep the block in a reported degraded state until software acknowledges the lane. An acknowledge only takes effect once that lane has rejoined the majority. If no two usable lanes agree, the block keeps the previous voted word and reports a no-majority fault for that vote.

Top module: `tmr_voter`

## Requirements
- R1: When all three lanes deliver the same word inside the window, that word is the voted output, no_maj_o is 0 and no lane flag is set by that vote.
- R2: When exactly two delivered words match and the third differs, the matching word is forwarded, the differing lane's disagree flag (bit i of dis_flag_o for lane i) is set, and degraded_o goes high.
- R3: Words are compared in full: lanes whose words differ in even a single bit do not count as agreeing.
- R4: When no two usable words match, voted_data_o keeps its previous value and no_maj_o is 1. no_maj_o holds its value until the next vote.
- R5: A lane with no valid pulse during the window sets its late flag (bit i of late_flag_o) and is left out of the vote. The two remaining lanes are forwarded if they match, otherwise R4 applies.
- R6: Disagree and late flags stay set through later clean votes until acknowledged.
- R7: A high ack_i bit for lane i clears both of that lane's flags only if lane i agreed with the majority in the most recent completed vote. Otherwise the acknowledge has no effect.
- R8: The window spans WIN_CYC cycles, starting with the cycle in which frame_i is high. voted_vld_o is high for exactly one cycle, the second cycle after the window's last cycle, and the voted outputs change at the same edge.
- R9: Only the first valid pulse of each lane within a window is used. frame_i while a window is already open is ignored.
- R10: During and right after reset, every output is 0.
- R11: degraded_o is high exactly when any disagree or late flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Opens a vote window |
| lane_vld_i | input | 3 | Per-lane word valid |
| lane_data_i | input | 3*DATA_W | Per-lane words, lane i in slice i |
| ack_i | input | 3 | Per-lane flag acknowledge |
| voted_data_o | output | DATA_W | Voted word |
| voted_vld_o | output | 1 | One-cycle pulse per completed vote |
| no_maj_o | output | 1 | Last vote found no majority |
| degraded_o | output | 1 | Any lane flag is set |
| dis_flag_o | output | 3 | Sticky disagree flags |
| late_flag_o | output | 3 | Sticky late flags |

## Verification
The hardest situation to reach is an acknowledge decision that depends on the last vote: a flagged lane must first be outvoted, then acknowledged while still disagreeing (the ack is rejected), then brought back into agreement before a second acknowledge clears it. Directed frames build this sequence for one lane. Seeded random frames then mix late lanes, single-bit word differences, repeated valid pulses, spurious frame strobes inside an open window and random acknowledge masks, so that late-lane exclusion meets remaining lanes that disagree.

// File: rtl/tmr_voter_pkg.sv
package tmr_voter_pkg;
  localparam int unsigned NLANE = 3;
  typedef logic [NLANE-1:0] lane_mask_t;
endpackage

// File: rtl/vote_window.sv
module vote_window #(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic win_start_o,
  output logic in_win_o,
  output logic close_o
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(WIN_CYC - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur_cnt;
  logic          last_cyc;
  logic          close_q;

  assign cur_cnt     = active_q ? cnt_q : '0;
  assign in_win_o    = active_q | frame_i;
  assign win_start_o = frame_i & ~active_q;
  assign last_cyc    = in_win_o && (cur_cnt == LAST_CNT);
  assign close_o     = close_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      close_q  <= 1'b0;
    end else begin
      close_q <= last_cyc;
      if (win_start_o) begin
        active_q <= ~last_cyc;
        cnt_q    <= CW'(1);
      end else if (active_q) begin
        if (last_cyc) active_q <= 1'b0;
        else          cnt_q    <= cnt_q + CW'(1);
      end
    end
  end

  // window never runs past its length
  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < CW'(WIN_CYC)));
  // a new window cannot start while one is open
  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !last_cyc) |=> active_q);
endmodule

// File: rtl/lane_capture.sv
module lane_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_start_i,
  input  logic              in_win_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              got_o,
  output logic [DATA_W-1:0] word_o
);
  logic              got_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q  <= 1'b0;
      word_q <= '0;
    end else if (win_start_i) begin
      got_q <= vld_i;
      if (vld_i) word_q <= data_i;
    end else if (in_win_i && vld_i && !got_q) begin
      got_q  <= 1'b1;
      word_q <= data_i;
    end
  end

  assign got_o  = got_q;
  assign word_o = word_q;

  // first word of a window is kept
  assert_first_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (got_q && !win_start_i) |=> $stable(word_q));
endmodule

// File: rtl/vote_core.sv
module vote_core
  import tmr_voter_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         check_i,
  input  lane_mask_t                   got_i,
  input  logic [NLANE-1:0][DATA_W-1:0] word_i,
  output logic                         have_o,
  output logic [DATA_W-1:0]            maj_o,
  output lane_mask_t                   agree_o
);
  // pair p compares lanes PA[p] and PB[p]
  localparam int unsigned NPAIR = 3;
  localparam int unsigned PA [NPAIR] = '{0, 0, 1};
  localparam int unsigned PB [NPAIR] = '{1, 2, 2};

  logic [NPAIR-1:0] pair_eq;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_eq[p] = got_i[PA[p]] && got_i[PB[p]] &&
                        (word_i[PA[p]] == word_i[PB[p]]);
  end

  assign have_o = |pair_eq;
  assign maj_o  = (pair_eq[0] | pair_eq[1]) ? word_i[0] : word_i[2];

  for (genvar l = 0; l < NLANE; l++) begin : g_agree
    assign agree_o[l] = got_i[l] && have_o && (word_i[l] == maj_o);
  end

  // a majority always has at least two supporters
  assert_two_agree_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (check_i && have_o) |-> ($countones(agree_o) >= 2));
  // missing lanes never support the vote
  assert_late_excluded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_i |-> ((agree_o & ~got_i) == '0));
endmodule

// File: rtl/fault_tracker.sv
module fault_tracker
  import tmr_voter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       close_i,
  input  logic       have_i,
  input  lane_mask_t got_i,
  input  lane_mask_t agree_i,
  input  lane_mask_t ack_i,
  output lane_mask_t dis_o,
  output lane_mask_t late_o,
  output logic       degraded_o
);
  lane_mask_t dis_q, late_q, ok_q;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic set_dis, set_late, clr;
    assign set_dis  = close_i && have_i && got_i[l] && !agree_i[l];
    assign set_late = close_i && !got_i[l];
    assign clr      = ack_i[l] && ok_q[l];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dis_q[l]  <= 1'b0;
        late_q[l] <= 1'b0;
        ok_q[l]   <= 1'b0;
      end else begin
        dis_q[l]  <= set_dis  | (dis_q[l]  & ~clr);
        late_q[l] <= set_late | (late_q[l] & ~clr);
        if (close_i) ok_q[l] <= agree_i[l];
      end
    end

    assert_dis_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dis_q[l]) |-> $past(ack_i[l]));
    assert_late_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(late_q[l]) |-> $past(ack_i[l]));
    assert_late_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (close_i && !got_i[l]) |=> late_q[l]);
  end

  assign dis_o      = dis_q;
  assign late_o     = late_q;
  assign degraded_o = |(dis_q | late_q);
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
  import tmr_voter_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned WIN_CYC = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         frame_i,
  input  logic [NLANE-1:0]             lane_vld_i,
  input  logic [NLANE-1:0][DATA_W-1:0] lane_data_i,
  input  logic [NLANE-1:0]             ack_i,
  output logic [DATA_W-1:0]            voted_data_o,
  output logic                         voted_vld_o,
  output logic                         no_maj_o,
  output logic                         degraded_o,
  output logic [NLANE-1:0]             dis_flag_o,
  output logic [NLANE-1:0]             late_flag_o
);
  logic win_start, in_win, close;
  lane_mask_t got, agree;
  logic [NLANE-1:0][DATA_W-1:0] word;
  logic have;
  logic [DATA_W-1:0] maj;

  vote_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i, .rst_ni, .frame_i,
    .win_start_o(win_start), .in_win_o(in_win), .close_o(close)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_cap
    lane_capture #(.DATA_W(DATA_W)) u_cap (
      .clk_i, .rst_ni,
      .win_start_i(win_start), .in_win_i(in_win),
      .vld_i(lane_vld_i[l]), .data_i(lane_data_i[l]),
      .got_o(got[l]), .word_o(word[l])
    );
  end

  vote_core #(.DATA_W(DATA_W)) u_vote (
    .clk_i, .rst_ni, .check_i(close),
    .got_i(got), .word_i(word),
    .have_o(have), .maj_o(maj), .agree_o(agree)
  );

  fault_tracker u_flt (
    .clk_i, .rst_ni, .close_i(close), .have_i(have),
    .got_i(got), .agree_i(agree), .ack_i(ack_i),
    .dis_o(dis_flag_o), .late_o(late_flag_o), .degraded_o(degraded_o)
  );

  logic [DATA_W-1:0] out_q;
  logic vld_q, nomaj_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      vld_q   <= 1'b0;
      nomaj_q <= 1'b0;
    end else begin
      vld_q <= close;
      if (close) begin
        nomaj_q <= ~have;
        if (have) out_q <= maj;
      end
    end
  end

  assign voted_data_o = out_q;
  assign voted_vld_o  = vld_q;
  assign no_maj_o     = nomaj_q;

  // no majority: output held
  assert_hold_on_nomaj_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (voted_vld_o && no_maj_o) |-> (voted_data_o == $past(voted_data_o)));
  // status only moves with a vote
  assert_nomaj_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !voted_vld_o |-> $stable(no_maj_o));
endmodule

// File: tb/tmr_voter_test.sv
`timescale 1ns/1ps
module tmr_voter_test;
  localparam int W  = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_i = 1'b0;
  logic [2:0] lane_vld_i = '0;
  logic [2:0][DW-1:0] lane_data_i = '0;
  logic [2:0] ack_i = '0;
  logic [DW-1:0] voted_data_o;
  logic voted_vld_o, no_maj_o, degraded_o;
  logic [2:0] dis_flag_o, late_flag_o;

  always #2.5 clk = ~clk;

  tmr_voter #(.DATA_W(DW), .WIN_CYC(W)) uut (
    .clk_i(clk), .rst_ni, .frame_i, .lane_vld_i, .lane_data_i, .ack_i,
    .voted_data_o, .voted_vld_o, .no_maj_o, .degraded_o, .dis_flag_o, .late_flag_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] m_out = '0;
  logic [2:0] m_dis = '0, m_late = '0, m_ok = '0;
  logic m_nomaj = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // returns {have, majority}
  function automatic logic [DW:0] ref_vote(logic [2:0][DW-1:0] w, logic [2:0] g);
    for (int i = 0; i < 3; i++)
      for (int j = i + 1; j < 3; j++)
        if (g[i] && g[j] && w[i] == w[j]) return {1'b1, w[i]};
    return '0;
  endfunction

  task automatic check_status(string req);
    chk(req, "dis", dis_flag_o, m_dis);
    chk(req, "late", late_flag_o, m_late);
    chk("R11", "degraded", degraded_o, |(m_dis | m_late));
  endtask

  // dly[i] = window cycle of lane i's word; >= W means late
  task automatic run_frame(logic [2:0][DW-1:0] w, logic [2:0][2:0] dly,
                           logic [2:0] extra, bit dup, string req);
    logic [2:0] g;
    logic [DW:0] v;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      frame_i = (k == 0) || (dup && k == 1);
      for (int i = 0; i < 3; i++) begin
        lane_vld_i[i]  = (int'(dly[i]) == k) || (extra[i] && int'(dly[i]) < k);
        lane_data_i[i] = (int'(dly[i]) == k) ? w[i] : DW'($urandom);
      end
    end
    @(negedge clk);
    frame_i = 1'b0;
    lane_vld_i = '0;
    chk("R8", "vld early", voted_vld_o, 1'b0);
    for (int i = 0; i < 3; i++) g[i] = int'(dly[i]) < W;
    v = ref_vote(w, g);
    for (int i = 0; i < 3; i++) begin
      if (!g[i]) m_late[i] = 1'b1;
      if (v[DW] && g[i] && w[i] != v[DW-1:0]) m_dis[i] = 1'b1;
      m_ok[i] = v[DW] && g[i] && w[i] == v[DW-1:0];
    end
    m_nomaj = ~v[DW];
    if (v[DW]) m_out = v[DW-1:0];
    @(negedge clk);
    chk("R8", "vld pulse", voted_vld_o, 1'b1);
    chk(req, "data", voted_data_o, m_out);
    chk(req, "no_maj", no_maj_o, m_nomaj);
    check_status(req);
  endtask

  task automatic do_ack(logic [2:0] mask, string req);
    @(negedge clk);
    ack_i = mask;
    lane_vld_i = 3'($urandom);
    @(negedge clk);
    ack_i = '0;
    lane_vld_i = '0;
    for (int i = 0; i < 3; i++)
      if (mask[i] && m_ok[i]) begin m_dis[i] = 1'b0; m_late[i] = 1'b0; end
    chk(req, "vld idle", voted_vld_o, 1'b0);
    check_status(req);
  endtask

  function automatic logic [2:0][DW-1:0] w3(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
    return {c, b, a};
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R10", "vld in reset", voted_vld_o, 1'b0);
    chk("R10", "data in reset", voted_data_o, '0);
    chk("R10", "no_maj in reset", no_maj_o, 1'b0);
    check_status("R10");
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", "data after reset", voted_data_o, '0);
    check_status("R10");

    run_frame(w3(16'h1234, 16'h1234, 16'h1234), {3'd0, 3'd1, 3'd2}, '0, 0, "R1");
    run_frame(w3(16'hbeef, 16'hbeef, 16'h0bad), {3'd3, 3'd0, 3'd1}, '0, 0, "R2");
    do_ack(3'b100, "R7");  // lane 2 was outvoted: rejected
    run_frame(w3(16'h7777, 16'h7777, 16'h7777), '0, '0, 0, "R6");
    do_ack(3'b100, "R7");  // now accepted
    run_frame(w3(16'h00f0, 16'h00f1, 16'h00f2), '0, '0, 0, "R3");
    run_frame(w3(16'haaaa, 16'h5555, 16'h1111), '0, '0, 0, "R4");
    run_frame(w3(16'h9999, 16'h4242, 16'h4242), {3'd1, 3'd0, 3'd4}, '0, 0, "R5");
    run_frame(w3(16'h4242, 16'h3131, 16'h4242), {3'd0, 3'd4, 3'd2}, '0, 0, "R5");
    run_frame(w3(16'h2468, 16'h2468, 16'h1357), {3'd4, 3'd0, 3'd0}, '0, 0, "R5");
    run_frame(w3(16'hc0de, 16'hc0de, 16'hc0de), '0, 3'b111, 1, "R9");
    run_frame(w3(16'hfeed, 16'hfeed, 16'hfeed), {3'd4, 3'd4, 3'd4}, '0, 0, "R5");
    run_frame(w3(16'h0101, 16'h0101, 16'h0101), {3'd2, 3'd1, 3'd0}, 3'b011, 0, "R1");
    do_ack(3'b111, "R7");

    for (int n = 0; n < 400; n++) begin
      logic [DW-1:0] base;
      logic [2:0][DW-1:0] w;
      logic [2:0][2:0] d;
      base = DW'($urandom);
      for (int i = 0; i < 3; i++) begin
        int r = int'($urandom % 8);
        w[i] = (r < 5) ? base : (r == 5) ? base ^ DW'(1 << ($urandom % DW)) : DW'($urandom);
        d[i] = ($urandom % 10 < 8) ? 3'($urandom % W) : 3'(W);
      end
      run_frame(w, d, 3'($urandom), ($urandom % 8) == 0, "R2");
      if ($urandom % 4 == 0) do_ack(3'($urandom), "R7");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule